// File: doc/BRIEF.md
# Polled Interrupt Acknowledge Unit

This block is the front end of an interrupt controller that is run by polling. Software does not take a hardware vector. It reads a register to learn which interrupt is the most urgent one pending, and that read also acknowledges it. Requests come in on level-sensitive lines from two timers and two DMA channels. Each line has its own mask bit and its own 3-bit priority.

Two read-only words share one single-cycle read strobe. The status word has no side effect. The poll word carries the same content, and reading it marks the reported source as in service. Acknowledging a source does not start any service routine and does not fetch a vector. An in-service source holds back every source of equal or lower priority. It does so until software writes an end-of-interrupt that names the source.

Top module: `pir_poll_unit`

## Requirements
- R1: While reset is asserted and after reset, `rd_data` is 0 and `in_service` is 0.
- R2: The read word is laid out as follows. Bit 15 is 1 exactly when an eligible source exists, and bits 14..5 are always 0. When bit 15 is 1, bits 4..0 hold the type code TYPE_BASE + slot, with slot 0 = timer 0, slot 2 = DMA 0, slot 3 = DMA 1 and slot 4 = timer 1 (TYPE_BASE defaults to 8).
- R3: The mask is 5 bits, one per slot (0 = timer 0, 2..3 = DMA channels, 4 = timer 1). A source whose mask bit is 1 is never reported. Slot 1 is reserved: it is never reported and never marked in service, whatever its request or mask bit.
- R4: The reported source is the eligible one with the smallest priority value. Slot i takes its priority from `irq_prio[3i+2:3i]`, where 0 is the most urgent. When priorities are equal, the lowest slot index wins.
- R5: A status read (`rd_sel`=0) returns the current word and leaves `in_service` unchanged.
- R6: A poll read (`rd_sel`=1) that returns bit 15 = 1 sets the `in_service` bit of the reported slot. No other read sets an `in_service` bit.
- R7: A pending source is eligible only if its priority value is strictly smaller than the smallest priority value among the sources in service.
- R8: Writing `eoi_wr`=1 with `eoi_idx` clears that slot's `in_service` bit at the next edge. A poll acknowledge in the same cycle is decided on the state before the write, and a set of a bit wins over a clear of the same bit.
- R9: A poll read that returns bit 15 = 0 returns an all-zero word and changes no state.
- R10: Requests are levels sampled every cycle. A request that drops before it is acknowledged is no longer reported by a read strobed in the cycle after the drop.
- R11: `rd_data` loads at the edge that ends the strobe cycle and reflects the state before that edge. It holds until the next strobe. An acknowledge is seen by a strobe in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 5 | Level request per slot (slot 1 reserved) |
| irq_mask | input | 5 | Mask per slot, 1 = masked |
| irq_prio | input | 15 | 3-bit priority per slot, 0 most urgent |
| rd_en | input | 1 | One-cycle read strobe |
| rd_sel | input | 1 | 0 = status word, 1 = poll word (acknowledging) |
| rd_data | output | 16 | Word returned by the last read |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_idx | input | 3 | Slot whose in-service bit the write clears |
| in_service | output | 5 | In-service bits per slot |

## Verification
A request change is registered at one edge, so the bench waits one cycle after changing inputs before it strobes a read. The read word and any change to `in_service` both land at the edge that closes the strobe cycle. The bench therefore samples both at the falling edge after that edge. It computes each expected word in advance from its own model of the in-service state, using only the state before the strobe. Back-to-back strobes check the word due on each of the two edges, and the checks after them confirm that the word holds while no strobe is given.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int WORD_W = 16;
  localparam int TYPE_W = 5;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic              hit;
    logic [TYPE_W-1:0] code;
  } pick_t;

  function automatic word_t pack_word(input pick_t p);
    word_t w;
    w = '0;
    if (p.hit) begin
      w[WORD_W-1]   = 1'b1;
      w[TYPE_W-1:0] = p.code;
    end
    return w;
  endfunction
endpackage

// File: rtl/pir_rst_sync.sv
module pir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sn = sync_q;
endmodule

// File: rtl/pir_pend_stage.sv
module pir_pend_stage #(
  parameter int               N    = 5,
  parameter logic [N-1:0]     RSVD = 5'b00010
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [N-1:0] req,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_d;
  logic [N-1:0] pend_q;
  logic         pend_en;

  always_comb begin
    pend_d  = req & ~RSVD;
    pend_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/pir_isr_bank.sv
module pir_isr_bank #(
  parameter int N      = 5,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 3
) (
  input  logic                clk,
  input  logic                rst_sn,
  input  logic [N*PRIO_W-1:0] prio_flat,
  input  logic                ack_vld,
  input  logic [IDX_W-1:0]    ack_idx,
  input  logic                eoi_wr,
  input  logic [IDX_W-1:0]    eoi_idx,
  output logic [N-1:0]        isr,
  output logic [PRIO_W:0]     thr
);
  logic [N-1:0] isr_q;
  logic [N-1:0] isr_d;
  logic [N-1:0] isr_en;
  logic [N-1:0] set_v;
  logic [N-1:0] clr_v;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign set_v[g]  = ack_vld && (ack_idx == IDX_W'(g));
    assign clr_v[g]  = eoi_wr  && (eoi_idx == IDX_W'(g));
    assign isr_en[g] = set_v[g] | clr_v[g];
    assign isr_d[g]  = set_v[g] | (isr_q[g] & ~clr_v[g]);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      isr_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (isr_en[i]) isr_q[i] <= isr_d[i];
      end
    end
  end

  // smallest priority value among in-service slots; 2**PRIO_W when none
  always_comb begin
    thr = {1'b1, {PRIO_W{1'b0}}};
    for (int i = 0; i < N; i++) begin
      if (isr_q[i] && ({1'b0, prio_flat[i*PRIO_W +: PRIO_W]} < thr)) begin
        thr = {1'b0, prio_flat[i*PRIO_W +: PRIO_W]};
      end
    end
  end

  assign isr = isr_q;
endmodule

// File: rtl/pir_resolver.sv
module pir_resolver #(
  parameter int N      = 5,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 3
) (
  input  logic [N-1:0]        pend,
  input  logic [N-1:0]        mask,
  input  logic [N*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W:0]     thr,
  output logic                hit,
  output logic [IDX_W-1:0]    win_idx
);
  logic [PRIO_W-1:0] prio_a [N];
  logic [N-1:0]      elig;
  logic [PRIO_W-1:0] best;

  for (genvar g = 0; g < N; g++) begin : g_src
    assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
    assign elig[g]   = pend[g] & ~mask[g] & ({1'b0, prio_a[g]} < thr);
  end

  // strict compare keeps the lower index on equal priority
  always_comb begin
    hit     = 1'b0;
    best    = '1;
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!hit || (prio_a[i] < best))) begin
        hit     = 1'b1;
        best    = prio_a[i];
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pir_poll_unit.sv
module pir_poll_unit
  import pir_pkg::*;
#(
  parameter int                    NUM_SRC   = 5,
  parameter int                    PRIO_W    = 3,
  parameter logic [TYPE_W-1:0]     TYPE_BASE = 5'd8,
  parameter logic [NUM_SRC-1:0]    RSVD_MAP  = 5'b00010
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          irq_req,
  input  logic [NUM_SRC-1:0]          irq_mask,
  input  logic [NUM_SRC*PRIO_W-1:0]   irq_prio,
  input  logic                        rd_en,
  input  logic                        rd_sel,
  output logic [WORD_W-1:0]           rd_data,
  input  logic                        eoi_wr,
  input  logic [$clog2(NUM_SRC)-1:0]  eoi_idx,
  output logic [NUM_SRC-1:0]          in_service
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic              rst_sn;
  logic [NUM_SRC-1:0] pend;
  logic [PRIO_W:0]   thr;
  logic              hit;
  logic [IDX_W-1:0]  win_idx;
  pick_t             pick;
  word_t             word_now;
  word_t             rd_q;
  logic              ack_vld;

  pir_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  pir_pend_stage #(.N(NUM_SRC), .RSVD(RSVD_MAP)) u_pend (
    .clk    (clk),
    .rst_sn (rst_sn),
    .req    (irq_req),
    .pend   (pend)
  );

  pir_resolver #(.N(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_res (
    .pend      (pend),
    .mask      (irq_mask),
    .prio_flat (irq_prio),
    .thr       (thr),
    .hit       (hit),
    .win_idx   (win_idx)
  );

  pir_isr_bank #(.N(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_isr (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .prio_flat (irq_prio),
    .ack_vld   (ack_vld),
    .ack_idx   (win_idx),
    .eoi_wr    (eoi_wr),
    .eoi_idx   (eoi_idx),
    .isr       (in_service),
    .thr       (thr)
  );

  always_comb begin
    pick.hit  = hit;
    pick.code = TYPE_BASE + TYPE_W'(win_idx);
    word_now  = pack_word(pick);
    ack_vld   = rd_en & rd_sel & hit;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= word_now;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/pir_poll_unit_chk.sv
module pir_poll_unit_chk #(
  parameter int                 NUM_SRC   = 5,
  parameter logic [4:0]         TYPE_BASE = 5'd8,
  parameter logic [NUM_SRC-1:0] RSVD_MAP  = 5'b00010
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rd_en,
  input logic                       rd_sel,
  input logic [15:0]                rd_data,
  input logic                       eoi_wr,
  input logic [$clog2(NUM_SRC)-1:0] eoi_idx,
  input logic [NUM_SRC-1:0]         in_service
);
  logic [4:0] off;
  logic       off_ok;

  always_comb begin
    off    = rd_data[4:0] - TYPE_BASE;
    off_ok = (32'(off) < NUM_SRC) && (((RSVD_MAP >> off) & NUM_SRC'(1)) == '0);
  end

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[14:5] == 10'd0);                                                   // R2
  AST_IDLE_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[15] |-> rd_data == 16'd0);                                        // R9
  AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15] |-> off_ok);                                                   // R3
  AST_RSVD_NEVER_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service & RSVD_MAP) == '0);                                            // R3
  AST_STATUS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && !eoi_wr) |=> $stable(in_service));                    // R5
  AST_SET_ONLY_BY_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_sel) |=> (in_service & ~$past(in_service)) == '0);           // R6
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !(rd_en && rd_sel)) |=>
      ((in_service >> $past(eoi_idx)) & NUM_SRC'(1)) == '0);                   // R8
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));                                              // R11
endmodule

bind pir_poll_unit pir_poll_unit_chk #(
  .NUM_SRC   (NUM_SRC),
  .TYPE_BASE (TYPE_BASE),
  .RSVD_MAP  (RSVD_MAP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .rd_sel     (rd_sel),
  .rd_data    (rd_data),
  .eoi_wr     (eoi_wr),
  .eoi_idx    (eoi_idx),
  .in_service (in_service)
);

// File: tb/pir_poll_unit_tb.sv
module pir_poll_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  req, mask;
  logic [14:0] prio;
  logic        rd_en, rd_sel, eoi_wr;
  logic [2:0]  eoi_idx;
  logic [15:0] rd_data;
  logic [4:0]  in_service;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [4:0] m_isr;

  always #5 clk = ~clk;

  pir_poll_unit u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(req), .irq_mask(mask), .irq_prio(prio),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .eoi_wr(eoi_wr),
    .eoi_idx(eoi_idx), .in_service(in_service)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected word from the requirements and the bench's own in-service copy
  function automatic logic [15:0] model_word(input logic [4:0] r, input logic [4:0] mk,
      input logic [14:0] p, input logic [4:0] isr, output int idx);
    int thr = 8;
    int bp  = 8;
    idx = -1;
    for (int i = 0; i < 5; i++)
      if (isr[i] && int'(p[3*i +: 3]) < thr) thr = int'(p[3*i +: 3]);
    for (int i = 0; i < 5; i++) begin
      if (i != 1 && r[i] && !mk[i] && int'(p[3*i +: 3]) < thr && int'(p[3*i +: 3]) < bp) begin
        bp  = int'(p[3*i +: 3]);
        idx = i;
      end
    end
    if (idx < 0) return 16'h0000;
    return 16'h8000 | 16'(8 + idx);
  endfunction

  task automatic setin(input logic [4:0] r, input logic [4:0] mk, input logic [14:0] p);
    req = r; mask = mk; prio = p;
    @(negedge clk);
  endtask

  task automatic step(input bit rd, input bit sel, input bit eo, input int eidx, input string tag);
    int wi;
    logic [15:0] ew, prev;
    ew   = model_word(req, mask, prio, m_isr, wi);
    prev = rd_data;
    rd_en = rd; rd_sel = sel; eoi_wr = eo; eoi_idx = 3'(eidx);
    @(negedge clk);
    rd_en = 1'b0; eoi_wr = 1'b0;
    if (eo) m_isr[eidx] = 1'b0;
    if (rd && sel && wi >= 0) m_isr[wi] = 1'b1;
    if (rd) chk({tag, " word"}, 32'(rd_data), 32'(ew));
    else    chk({tag, " word held"}, 32'(rd_data), 32'(prev));
    chk({tag, " in_service"}, 32'(in_service), 32'(m_isr));
  endtask

  function automatic logic [14:0] mkprio(input int p0, input int p2, input int p3, input int p4);
    return {3'(p4), 3'(p3), 3'(p2), 3'd0, 3'(p0)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [14:0] p;
    int wi;
    logic [15:0] ew;
    rst_n = 1'b0; req = '0; mask = '0; prio = '0;
    rd_en = 1'b0; rd_sel = 1'b0; eoi_wr = 1'b0; eoi_idx = '0; m_isr = '0;
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", 32'(rd_data), 32'h0);
    chk("R1 in_service in reset", 32'(in_service), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rd_data after reset", 32'(rd_data), 32'h0);
    step(1, 0, 0, 0, "R1 status after reset");

    // sweep every request and mask pattern with varied priorities
    for (int r = 0; r < 32; r++) begin
      for (int m = 0; m < 32; m++) begin
        for (int i = 0; i < 5; i++) p[3*i +: 3] = 3'((r + 2*m + 3*i) % 8);
        setin(5'(r), 5'(m), p);
        step(1, 0, 0, 0, "R2,R3,R4,R10 sweep");
      end
    end

    // R4 ties: equal priorities, lowest slot wins
    setin(5'b11101, 5'b00000, mkprio(3, 3, 3, 3));
    step(1, 0, 0, 0, "R4 tie");
    chk("R4 tie code", 32'(rd_data), 32'h8008);
    setin(5'b11100, 5'b00000, mkprio(3, 3, 3, 3));
    step(1, 0, 0, 0, "R4 tie dma0");
    chk("R4 tie dma0 code", 32'(rd_data), 32'h800A);

    // R5: repeated status reads leave state alone
    step(1, 0, 0, 0, "R5 status a");
    step(1, 0, 0, 0, "R5 status b");
    chk("R5 still dma0", 32'(rd_data), 32'h800A);

    // R6, R7, R9 acknowledge chain
    setin(5'b00001, 5'b00000, mkprio(6, 2, 4, 7));
    step(1, 1, 0, 0, "R6 poll timer0");
    chk("R6 timer0 in service", 32'(in_service), 32'h01);
    setin(5'b10101, 5'b00000, mkprio(6, 2, 4, 7));
    step(1, 0, 0, 0, "R7 dma0 preempts");
    chk("R7 dma0 code", 32'(rd_data), 32'h800A);
    step(1, 1, 0, 0, "R6 poll dma0");
    step(1, 0, 0, 0, "R7 nothing above dma0");
    setin(5'b11101, 5'b00000, mkprio(6, 2, 4, 7));
    step(1, 0, 0, 0, "R7 dma1 held back");
    step(1, 1, 0, 0, "R9 empty poll");
    chk("R9 empty poll zero", 32'(rd_data), 32'h0);
    chk("R9 in_service kept", 32'(in_service), 32'h05);

    // R8 end of interrupt, alone and together with a poll
    step(0, 0, 1, 2, "R8 eoi dma0");
    chk("R8 dma0 cleared", 32'(in_service), 32'h01);
    step(1, 0, 0, 0, "R8 after eoi");
    step(1, 1, 0, 0, "R8 poll after eoi");
    step(1, 1, 1, 3, "R8 poll with eoi same cycle");
    step(1, 1, 1, 2, "R8 set wins over clear");
    for (int i = 0; i < 5; i++) step(0, 0, 1, i, "R8 clear all");
    chk("R8 all cleared", 32'(in_service), 32'h0);

    // R10 level requests
    setin(5'b00100, 5'b00000, mkprio(1, 1, 1, 1));
    step(1, 0, 0, 0, "R10 dma0 pending");
    setin(5'b00000, 5'b00000, mkprio(1, 1, 1, 1));
    step(1, 0, 0, 0, "R10 dropped");
    chk("R10 dropped zero", 32'(rd_data), 32'h0);
    step(1, 1, 0, 0, "R10 poll after drop");

    // R3 all masked, reserved slot requesting
    setin(5'b11111, 5'b11101, mkprio(0, 0, 0, 0));
    step(1, 1, 0, 0, "R3 masked poll");
    chk("R3 nothing served", 32'(in_service), 32'h0);

    // R11 back-to-back poll strobes, then hold
    setin(5'b01001, 5'b00000, mkprio(5, 0, 1, 0));
    ew = model_word(req, mask, prio, m_isr, wi);
    rd_en = 1'b1; rd_sel = 1'b1;
    @(negedge clk);
    chk("R11 first strobe", 32'(rd_data), 32'(ew));
    if (wi >= 0) m_isr[wi] = 1'b1;
    ew = model_word(req, mask, prio, m_isr, wi);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R11 second strobe sees ack", 32'(rd_data), 32'(ew));
    chk("R11 second strobe zero", 32'(rd_data), 32'h0);
    repeat (3) @(negedge clk);
    chk("R11 word held", 32'(rd_data), 32'h0);
    chk("R11 in_service dma1", 32'(in_service), 32'h08);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule